// File: doc/BRIEF.md
# Sprite DMA Fetch Scheduler

This block plans the memory reads that feed the sprite pattern registers on each scan line. When the line timing logic pulses `line_start` with the number of the line about to be drawn, the scheduler captures the control inputs. If the line is in the visible window and sprite fetching is enabled, it issues a short burst of fetch requests. The missile byte is read first. The four player bytes follow on consecutive cycles. With every request the block also outputs the address, a slot tag, load strobes for the pattern registers that should take the returned byte, and a discard flag for a read whose data goes nowhere.

The sprite memory layout depends on the vertical resolution mode. In double-line mode each byte covers two scan lines, so the address steps every second line while the pattern registers are still reloaded on every line. In single-line mode both the address and the registers change on every line. A per-object vertical-delay mask suppresses loads on even lines. The block also decodes whether the playfield is active from the display-list enable bit and the width field.

Top module: `sdf_sched`

## Requirements
- R1: The control field `dma_ctl[3:2]` selects the fetches. 00 issues no fetch. 01 (missiles only) issues one fetch, for slot 0. 10 (players only) and 11 (both) issue five fetches, for slots 0 to 4.
- R2: A burst begins two clock edges after the edge that samples `line_start`. Within a burst, `fetch_slot` is 0 for the missile byte and 1 to 4 for players 0 to 3, on consecutive cycles.
- R3: Fetches are issued only for scan lines 8 to 247 inclusive.
- R4: When `dma_ctl[4]`=0 (double-line), the address is `{pm_base_hi, 10'b0} + (3+slot)*128 + (line>>1)`.
- R5: When `dma_ctl[4]`=1 (single-line), the address is `{pm_base_hi[5:1], 11'b0} + (3+slot)*256 + line`.
- R6: When players are enabled and missiles are not, the slot 0 fetch is still issued, with `missile_load`=0 and `fetch_discard`=1.
- R7: `vdelay[3:0]` covers missiles 0 to 3 and `vdelay[7:4]` covers players 0 to 3. On an even line, a set bit clears that object's load strobe. On an odd line the mask has no effect.
- R8: `player_load` is one-hot on a player slot and zero on slot 0. `fetch_discard` is 1 exactly when a fetch raises no load strobe.
- R9: `playfield_on` is 1 one edge after `dma_ctl[5]`=1 with `dma_ctl[1:0]`≠0, and 0 otherwise.
- R10: After synchronous reset, all outputs are zero.
- R11: The line number, controls, mask and base are captured at the accepted `line_start`. Later changes to them do not alter the burst in progress. A `line_start` that arrives during a burst is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse at the start of a scan line |
| scan_line | input | 9 | Number of the line being started |
| dma_ctl | input | 6 | [1:0] width, [2] missile, [3] player, [4] single-line, [5] display list |
| pm_base_hi | input | 6 | Sprite memory base, address bits 15:10 |
| vdelay | input | 8 | Vertical-delay mask, missiles in [3:0], players in [7:4] |
| fetch_req | output | 1 | Fetch request valid |
| fetch_addr | output | 16 | Fetch address |
| fetch_slot | output | 3 | Slot tag, 0 for missile, 1 to 4 for players |
| player_load | output | 4 | Player pattern register load strobes |
| missile_load | output | 4 | Per-missile load strobes for the shared byte |
| fetch_discard | output | 1 | The fetched data is delivered nowhere |
| playfield_on | output | 1 | Playfield generation enabled |

## Verification
Two effects can decide the missile slot in the same cycle. One is the forced, discarded missile fetch in players-only mode. The other is the vertical-delay mask on an even line. The bench runs a players-only line on an even line with the missile delay bits set, and another with every delay bit set. It expects every such slot to be issued with no strobe and with the discard flag raised. The same pattern on an odd line shows that the mask drops out while the forced discard stays.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int N_PLAYERS = 4;
  localparam int N_SLOTS   = N_PLAYERS + 1;
  localparam int SLOT_W    = $clog2(N_SLOTS);
  localparam int CTL_W     = 6;

  typedef struct packed {
    logic       dlist_on;
    logic       single_res;
    logic       player_on;
    logic       missile_on;
    logic [1:0] width;
  } ctl_t;

  function automatic ctl_t decode_ctl(input logic [CTL_W-1:0] c);
    ctl_t r;
    r.width      = c[1:0];
    r.missile_on = c[2];
    r.player_on  = c[3];
    r.single_res = c[4];
    r.dlist_on   = c[5];
    return r;
  endfunction
endpackage

// File: rtl/sdf_line_gate.sv
module sdf_line_gate #(
  parameter int LINE_W     = 9,
  parameter int FIRST_LINE = 8,
  parameter int LAST_LINE  = 247
) (
  input  logic              line_start,
  input  logic              busy,
  input  logic [LINE_W-1:0] scan_line,
  input  logic              missile_on,
  input  logic              player_on,
  output logic              accept
);
  localparam logic [LINE_W-1:0] LO = LINE_W'(FIRST_LINE);
  localparam logic [LINE_W-1:0] HI = LINE_W'(LAST_LINE);

  logic in_window;
  assign in_window = (scan_line >= LO) && (scan_line <= HI);
  assign accept    = line_start && !busy && in_window && (missile_on || player_on);
endmodule

// File: rtl/sdf_slot_seq.sv
module sdf_slot_seq
  import sdf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_full,
  output logic              busy,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST_FULL = SLOT_W'(N_SLOTS - 1);

  logic full;
  logic [SLOT_W-1:0] last_slot;
  assign last_slot = full ? LAST_FULL : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      slot <= '0;
      full <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      slot <= '0;
      full <= start_full;
    end else if (busy) begin
      if (slot == last_slot) begin
        busy <= 1'b0;
        slot <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdf_addr_gen.sv
module sdf_addr_gen
  import sdf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 9
) (
  input  logic [ADDR_W-11:0] base_hi,
  input  logic               single_res,
  input  logic [LINE_W-1:0]  line,
  input  logic [SLOT_W-1:0]  slot,
  output logic [ADDR_W-1:0]  addr
);
  localparam int DBL_STRIDE = 128;
  localparam int SGL_STRIDE = 256;
  localparam int FIRST_AREA = 3;

  logic [ADDR_W-1:0] dbl_off [N_SLOTS];
  logic [ADDR_W-1:0] sgl_off [N_SLOTS];

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_off
    assign dbl_off[s] = ADDR_W'((FIRST_AREA + s) * DBL_STRIDE);
    assign sgl_off[s] = ADDR_W'((FIRST_AREA + s) * SGL_STRIDE);
  end

  logic [ADDR_W-1:0] dbl_region, sgl_region, dbl_line, sgl_line;
  assign dbl_region = {base_hi, 10'b0};
  assign sgl_region = {base_hi[ADDR_W-11:1], 11'b0};
  assign dbl_line   = ADDR_W'(line[LINE_W-1:1]);
  assign sgl_line   = ADDR_W'(line);

  always_comb begin
    addr = '0;
    for (int s = 0; s < N_SLOTS; s++) begin
      if (slot == SLOT_W'(s)) begin
        addr = single_res ? (sgl_region + sgl_off[s] + sgl_line)
                          : (dbl_region + dbl_off[s] + dbl_line);
      end
    end
  end
endmodule

// File: rtl/sdf_load_mask.sv
module sdf_load_mask
  import sdf_pkg::*;
(
  input  logic                 missile_on,
  input  logic                 player_on,
  input  logic                 even_line,
  input  logic [2*N_PLAYERS-1:0] vdel,
  input  logic [SLOT_W-1:0]    slot,
  output logic [N_PLAYERS-1:0] p_load,
  output logic [N_PLAYERS-1:0] m_load,
  output logic                 discard
);
  logic [N_PLAYERS-1:0] m_keep, p_keep;
  assign m_keep = even_line ? ~vdel[N_PLAYERS-1:0] : '1;
  assign p_keep = even_line ? ~vdel[2*N_PLAYERS-1:N_PLAYERS] : '1;

  always_comb begin
    p_load = '0;
    m_load = '0;
    if (slot == '0) begin
      if (missile_on) m_load = m_keep;
    end else begin
      for (int p = 0; p < N_PLAYERS; p++) begin
        if (slot == SLOT_W'(p + 1)) p_load[p] = player_on && p_keep[p];
      end
    end
  end

  assign discard = (p_load == '0) && (m_load == '0);
endmodule

// File: rtl/sdf_sched.sv
module sdf_sched
  import sdf_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_W     = 9,
  parameter int FIRST_LINE = 8,
  parameter int LAST_LINE  = 247
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_start,
  input  logic [LINE_W-1:0]    scan_line,
  input  logic [CTL_W-1:0]     dma_ctl,
  input  logic [ADDR_W-11:0]   pm_base_hi,
  input  logic [2*N_PLAYERS-1:0] vdelay,
  output logic                 fetch_req,
  output logic [ADDR_W-1:0]    fetch_addr,
  output logic [SLOT_W-1:0]    fetch_slot,
  output logic [N_PLAYERS-1:0] player_load,
  output logic [N_PLAYERS-1:0] missile_load,
  output logic                 fetch_discard,
  output logic                 playfield_on
);
  localparam int BASE_W = ADDR_W - 10;

  ctl_t ctl_in;
  assign ctl_in = decode_ctl(dma_ctl);

  logic busy, accept;
  logic [SLOT_W-1:0] slot;

  sdf_line_gate #(
    .LINE_W(LINE_W), .FIRST_LINE(FIRST_LINE), .LAST_LINE(LAST_LINE)
  ) u_gate (
    .line_start(line_start),
    .busy(busy),
    .scan_line(scan_line),
    .missile_on(ctl_in.missile_on),
    .player_on(ctl_in.player_on),
    .accept(accept)
  );

  sdf_slot_seq u_seq (
    .clk(clk),
    .rst(rst),
    .start(accept),
    .start_full(ctl_in.player_on),
    .busy(busy),
    .slot(slot)
  );

  logic [LINE_W-1:0]      lat_line;
  logic                   lat_m, lat_p, lat_s;
  logic [2*N_PLAYERS-1:0] lat_vd;
  logic [BASE_W-1:0]      lat_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_line <= '0;
      lat_m    <= 1'b0;
      lat_p    <= 1'b0;
      lat_s    <= 1'b0;
      lat_vd   <= '0;
      lat_base <= '0;
    end else if (accept) begin
      lat_line <= scan_line;
      lat_m    <= ctl_in.missile_on;
      lat_p    <= ctl_in.player_on;
      lat_s    <= ctl_in.single_res;
      lat_vd   <= vdelay;
      lat_base <= pm_base_hi;
    end
  end

  logic [ADDR_W-1:0]    nx_addr;
  logic [N_PLAYERS-1:0] nx_pl, nx_ml;
  logic                 nx_disc;

  sdf_addr_gen #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_addr (
    .base_hi(lat_base),
    .single_res(lat_s),
    .line(lat_line),
    .slot(slot),
    .addr(nx_addr)
  );

  sdf_load_mask u_mask (
    .missile_on(lat_m),
    .player_on(lat_p),
    .even_line(!lat_line[0]),
    .vdel(lat_vd),
    .slot(slot),
    .p_load(nx_pl),
    .m_load(nx_ml),
    .discard(nx_disc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_req     <= 1'b0;
      fetch_addr    <= '0;
      fetch_slot    <= '0;
      player_load   <= '0;
      missile_load  <= '0;
      fetch_discard <= 1'b0;
      playfield_on  <= 1'b0;
    end else begin
      fetch_req     <= busy;
      fetch_addr    <= busy ? nx_addr : '0;
      fetch_slot    <= busy ? slot : '0;
      player_load   <= busy ? nx_pl : '0;
      missile_load  <= busy ? nx_ml : '0;
      fetch_discard <= busy && nx_disc;
      playfield_on  <= ctl_in.dlist_on && (ctl_in.width != 2'b00);
    end
  end
endmodule

// File: rtl/sdf_sched_chk.sv
module sdf_sched_chk #(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              line_start,
  input logic [LINE_W-1:0] scan_line,
  input logic [5:0]        dma_ctl,
  input logic              fetch_req,
  input logic [2:0]        fetch_slot,
  input logic [3:0]        player_load,
  input logic [3:0]        missile_load,
  input logic              fetch_discard,
  input logic              playfield_on
);
  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!fetch_req && player_load == 4'd0 && missile_load == 4'd0 && !fetch_discard));

  // R2
  slot_order_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_slot != 3'd0) |-> ($past(fetch_req) && fetch_slot == $past(fetch_slot) + 3'd1));

  // R3
  window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch_req) |-> ($past(line_start, 2) && $past(scan_line, 2) >= 9'd8 && $past(scan_line, 2) <= 9'd247));

  // R8
  player_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(player_load) && (fetch_slot == 3'd0 || player_load == 4'd0 || fetch_req));

  // R8
  slot0_no_player_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_slot == 3'd0) |-> player_load == 4'd0);

  // R6
  discard_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && fetch_discard) |-> (player_load == 4'd0 && missile_load == 4'd0));

  // R8
  deliver_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !fetch_discard) |-> ($countones({player_load, missile_load}) != 0));

  // R9
  playfield_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (playfield_on == ($past(dma_ctl[5]) && $past(dma_ctl[1:0]) != 2'b00)));
endmodule

bind sdf_sched sdf_sched_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .line_start(line_start),
  .scan_line(scan_line),
  .dma_ctl(dma_ctl),
  .fetch_req(fetch_req),
  .fetch_slot(fetch_slot),
  .player_load(player_load),
  .missile_load(missile_load),
  .fetch_discard(fetch_discard),
  .playfield_on(playfield_on)
);

// File: tb/tb_sdf_sched.sv
module tb_sdf_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_start = 1'b0;
  logic [8:0]  scan_line = '0;
  logic [5:0]  dma_ctl = '0;
  logic [5:0]  pm_base_hi = '0;
  logic [7:0]  vdelay = '0;
  logic        fetch_req, fetch_discard, playfield_on;
  logic [15:0] fetch_addr;
  logic [2:0]  fetch_slot;
  logic [3:0]  player_load, missile_load;

  sdf_sched dut (
    .clk(clk), .rst(rst), .line_start(line_start), .scan_line(scan_line),
    .dma_ctl(dma_ctl), .pm_base_hi(pm_base_hi), .vdelay(vdelay),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_slot(fetch_slot),
    .player_load(player_load), .missile_load(missile_load),
    .fetch_discard(fetch_discard), .playfield_on(playfield_on)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [15:0] addr;
    logic [2:0]  slot;
    logic [3:0]  pl;
    logic [3:0]  ml;
    logic        disc;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  function automatic item_t mk(int slot, int ln, logic [5:0] c, logic [7:0] vd, logic [5:0] bh);
    item_t it;
    bit even = (ln % 2) == 0;
    it.slot = 3'(slot);
    if (c[4]) it.addr = {bh[5:1], 11'b0} + 16'((3 + slot) * 256) + 16'(ln);
    else      it.addr = {bh, 10'b0} + 16'((3 + slot) * 128) + 16'(ln / 2);
    it.pl = '0;
    it.ml = '0;
    if (slot == 0) begin
      if (c[2]) it.ml = even ? ~vd[3:0] : 4'hF;
    end else if (c[3]) begin
      it.pl = (4'b1 << (slot - 1)) & (even ? ~vd[7:4] : 4'hF);
    end
    it.disc = (it.pl == 0) && (it.ml == 0);
    return it;
  endfunction

  task automatic push_line(int ln, logic [5:0] c, logic [7:0] vd, logic [5:0] bh, string tag);
    if (ln >= 8 && ln <= 247 && (c[2] || c[3])) begin
      exp_q.push_back(mk(0, ln, c, vd, bh));
      tag_q.push_back(tag);
      if (c[3]) for (int s = 1; s <= 4; s++) begin
        exp_q.push_back(mk(s, ln, c, vd, bh));
        tag_q.push_back(tag);
      end
    end
  endtask

  task automatic run_line(int ln, logic [5:0] c, logic [7:0] vd, logic [5:0] bh, string tag);
    @(negedge clk);
    scan_line = 9'(ln); dma_ctl = c; vdelay = vd; pm_base_hi = bh; line_start = 1'b1;
    push_line(ln, c, vd, bh, tag);
    @(negedge clk);
    line_start = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic check1(string tag, logic [31:0] act, logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && fetch_req) begin
      item_t got, e;
      string t;
      got = {fetch_addr, fetch_slot, player_load, missile_load, fetch_discard};
      vectors++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1 R3 unexpected fetch actual=%h expected=none", got);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, got, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check1("R10 reset", {fetch_req, fetch_discard, player_load, missile_load, fetch_slot, playfield_on}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check1("R10 after reset", {fetch_req, fetch_addr}, 32'd0);

    // double-line, both enabled
    run_line(100, 6'h0C, 8'h00, 6'h2C, "R4 R2 R1");
    run_line(101, 6'h0C, 8'h00, 6'h2C, "R4 odd line");
    // single-line
    run_line(9,   6'h1C, 8'h00, 6'h15, "R5 R2");
    run_line(200, 6'h1C, 8'h00, 6'h3F, "R5");
    // enable decoding
    run_line(50,  6'h04, 8'h00, 6'h08, "R1 missile only");
    run_line(51,  6'h08, 8'h00, 6'h08, "R6 player only");
    run_line(60,  6'h00, 8'h00, 6'h08, "R1 off");
    // window edges
    run_line(7,   6'h0C, 8'h00, 6'h04, "R3 line 7");
    run_line(8,   6'h0C, 8'h00, 6'h04, "R3 line 8");
    run_line(247, 6'h1C, 8'h00, 6'h04, "R3 line 247");
    run_line(248, 6'h0C, 8'h00, 6'h04, "R3 line 248");
    // vertical delay
    run_line(120, 6'h0C, 8'hA5, 6'h10, "R7 even");
    run_line(121, 6'h0C, 8'hA5, 6'h10, "R7 odd");
    run_line(130, 6'h1C, 8'h5A, 6'h12, "R7 single even");
    // forced discard with vdelay in the same slot
    run_line(140, 6'h08, 8'h0F, 6'h20, "R6 R7 R8 even");
    run_line(140, 6'h0C, 8'hFF, 6'h20, "R8 all masked");
    run_line(141, 6'h08, 8'h0F, 6'h20, "R6 odd");

    // R11: capture and busy-ignore
    @(negedge clk);
    scan_line = 9'd90; dma_ctl = 6'h0C; vdelay = 8'h00; pm_base_hi = 6'h30; line_start = 1'b1;
    push_line(90, 6'h0C, 8'h00, 6'h30, "R11 latched");
    @(negedge clk);
    line_start = 1'b0; scan_line = 9'd33; dma_ctl = 6'h1C; vdelay = 8'hFF; pm_base_hi = 6'h01;
    @(negedge clk);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    repeat (8) @(negedge clk);
    check1("R11 no extra burst", exp_q.size(), 0);

    // R9 playfield decode
    @(negedge clk); dma_ctl = 6'h20;
    @(negedge clk); check1("R9 width zero", playfield_on, 0);
    dma_ctl = 6'h22;
    @(negedge clk); check1("R9 enabled", playfield_on, 1);
    dma_ctl = 6'h03;
    @(negedge clk); check1("R9 list off", playfield_on, 0);
    dma_ctl = 6'h3F;
    @(negedge clk); check1("R9 wide", playfield_on, 1);

    repeat (4) @(negedge clk);
    check1("R2 queue drained", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule